// File: doc/BRIEF.md
# Instruction Address Match Interrupt Unit

This unit watches the stream of instruction start addresses coming from a processor core. It compares each one against eight programmable 24-bit breakpoint addresses. When the core signals that an instruction is about to begin at an address equal to an enabled entry, the unit raises an interrupt request so that the interrupt is taken before that instruction runs. The request also reports which entry fired. Only instruction start addresses are compared. Operand fetches, table reads and bytes inside an instruction never trigger it. The unit has no global mask or priority input, so nothing outside its own enable bits can suppress the request.

Software sets the unit up through a small word-addressed register port with byte enables. Each entry owns one 4-byte slot, and the three low bytes of that slot hold the address. A single enable byte carries one bit per entry. The slots sit at fixed, non-contiguous offsets because neighbouring decode logic reserves the gaps. Vectoring, stacking and pipeline flush are handled by the core.

Top module: `addr_match_irq`

## Requirements
- R1: There are eight entries, each holding a 24-bit address. Entry i sits at register word index 4,5,6,7,10,11,14,15 for i = 0..7 (byte offsets 10h,14h,18h,1Ch,28h,2Ch,38h,3Ch). Byte lane b (cfg_be[b], data bits 8b+7:8b) for b = 0..2 writes address bits 8b+7:8b, and each lane can be written on its own.
- R2: After reset every entry address is 000000h, the enable byte is 00h, irq_req is 0 and irq_idx is 0.
- R3: The enable byte is at word index 2, lane 1 (byte offset 09h, data bits 15:8). Bit i set to 1 enables entry i. A disabled entry never raises a request.
- R4: If ins_start is 1 and ins_addr equals the address of an enabled entry at a clock edge, then irq_req is 1 for exactly the following cycle and irq_idx gives that entry's number.
- R5: An address presented while ins_start is 0 never raises a request, even if it equals an enabled entry's address. Such addresses model data or mid-instruction accesses.
- R6: When several enabled entries match the same start address, irq_idx reports the lowest-numbered one.
- R7: A register write in the same cycle as an instruction start does not affect that start's comparison. The write applies from the next instruction start onward.
- R8: A read returns its data on cfg_rdata one cycle after cfg_rd. Lane 3 of an address slot reads 0, and writes to lane 3 have no effect. The enable word reads the enable byte in bits 15:8 and 0 elsewhere. Unmapped words read 0.
- R9: Instruction starts on consecutive cycles are each compared on their own, giving one pulse per matching start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_word | input | 6 | Register word index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| ins_start | input | 1 | An instruction begins at ins_addr |
| ins_addr | input | 24 | Current address from the core |
| irq_req | output | 1 | Match interrupt request pulse |
| irq_idx | output | 3 | Number of the matching entry |

## Verification
The bench uses the default parameters: eight entries, a 24-bit address and a 6-bit word index. With these values every irregular slot position is reachable, as is the full address range up to FFFFFFh. Priority is tested with two enabled entries that hold the same address. The bench also interleaves register writes with instruction starts in the same cycle and sends starts on back-to-back cycles. It shows that the enable bits, the start strobe and the byte enables each gate behaviour on their own.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int CFG_DW  = 32;
  localparam int CFG_BEW = CFG_DW / 8;
  localparam int EN_WORD = 2;
  localparam int EN_LANE = 1;

  // Word index of the slot holding entry idx; gaps are reserved for neighbours.
  function automatic int slot_word(input int idx);
    if (idx < 4)      return 4 + idx;
    else if (idx < 6) return 10 + (idx - 4);
    else              return 14 + (idx - 6);
  endfunction
endpackage

// File: rtl/amu_regs.sv
module amu_regs
  import amu_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 24,
  parameter int CFG_AW = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_wr,
  input  logic                          cfg_rd,
  input  logic [CFG_AW-1:0]             cfg_word,
  input  logic [CFG_BEW-1:0]            cfg_be,
  input  logic [CFG_DW-1:0]             cfg_wdata,
  output logic [CFG_DW-1:0]             cfg_rdata,
  output logic [N_ENT-1:0][ADDR_W-1:0]  addr_vec,
  output logic [N_ENT-1:0]              en_vec
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic [N_ENT-1:0]             slot_hit;
  logic [N_ENT-1:0][ADDR_W-1:0] addr_q;
  logic [N_ENT-1:0]             en_q;
  logic                         en_sel;
  logic [CFG_DW-1:0]            rd_mux;
  logic                         unused_hi;

  assign unused_hi = ^{cfg_wdata[CFG_DW-1:ADDR_W], cfg_be[CFG_BEW-1:ADDR_BYTES]};
  assign en_sel    = (cfg_word == CFG_AW'(EN_WORD));

  generate
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      assign slot_hit[i] = (cfg_word == CFG_AW'(slot_word(i)));

      always_ff @(posedge clk) begin
        if (rst) begin
          addr_q[i] <= '0;
        end else if (cfg_wr && slot_hit[i]) begin
          for (int b = 0; b < ADDR_BYTES; b++) begin
            if (cfg_be[b]) addr_q[i][b*8 +: 8] <= cfg_wdata[b*8 +: 8];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                                en_q <= '0;
    else if (cfg_wr && en_sel && cfg_be[EN_LANE]) en_q <= cfg_wdata[EN_LANE*8 +: N_ENT];
  end

  always_comb begin
    rd_mux = '0;
    if (en_sel) rd_mux[EN_LANE*8 +: N_ENT] = en_q;
    for (int i = 0; i < N_ENT; i++) begin
      if (slot_hit[i]) rd_mux[ADDR_W-1:0] = addr_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  assign addr_vec = addr_q;
  assign en_vec   = en_q;

  // R2: state cleared by reset
  assert_rst_clear_R2: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (en_q == '0 && addr_q == '0 && cfg_rdata == '0));

  // R8: top byte of any read is zero
  assert_lane3_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_rd) |-> (cfg_rdata[CFG_DW-1:ADDR_W] == '0));

  // R3: enables change only through a write
  assert_en_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_wr) |-> $stable(en_q));
endmodule

// File: rtl/amu_cmp.sv
module amu_cmp #(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0]             ins_addr,
  input  logic [N_ENT-1:0][ADDR_W-1:0]  addr_vec,
  input  logic [N_ENT-1:0]              en_vec,
  output logic [N_ENT-1:0]              hit
);
  generate
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
      assign hit[i] = en_vec[i] && (addr_vec[i] == ins_addr);
    end
  endgenerate
endmodule

// File: rtl/amu_prio.sv
module amu_prio #(
  parameter int N_ENT = 8,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] hit,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end
  assign any = |hit;
endmodule

// File: rtl/addr_match_irq.sv
module addr_match_irq
  import amu_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 24,
  parameter int CFG_AW = 6,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_word,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ins_start,
  input  logic [ADDR_W-1:0] ins_addr,
  output logic              irq_req,
  output logic [IDX_W-1:0]  irq_idx
);
  logic [N_ENT-1:0][ADDR_W-1:0] addr_vec;
  logic [N_ENT-1:0]             en_vec;
  logic [N_ENT-1:0]             hit;
  logic                         any_hit;
  logic [IDX_W-1:0]             win_idx;

  amu_regs #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_word(cfg_word),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .addr_vec(addr_vec), .en_vec(en_vec)
  );

  amu_cmp #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_cmp (
    .ins_addr(ins_addr), .addr_vec(addr_vec), .en_vec(en_vec), .hit(hit)
  );

  amu_prio #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_prio (
    .hit(hit), .any(any_hit), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_idx <= '0;
    end else begin
      irq_req <= ins_start && any_hit;
      irq_idx <= (ins_start && any_hit) ? win_idx : '0;
    end
  end

  // Shadow copies of the state seen at the previous edge, for checking only.
  logic [N_ENT-1:0][ADDR_W-1:0] chk_addr_d;
  logic [N_ENT-1:0]             chk_en_d;
  logic [ADDR_W-1:0]            chk_ins_d;
  logic                         chk_lower;

  always_ff @(posedge clk) begin
    chk_addr_d <= addr_vec;
    chk_en_d   <= en_vec;
    chk_ins_d  <= ins_addr;
  end

  always_comb begin
    chk_lower = 1'b0;
    for (int j = 0; j < N_ENT; j++) begin
      if (j < int'(irq_idx) && chk_en_d[j] && chk_addr_d[j] == chk_ins_d) chk_lower = 1'b1;
    end
  end

  // R5: a request always follows an instruction start
  assert_start_only_R5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(ins_start));

  // R4: the reported entry was enabled and held the start address
  assert_entry_match_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (chk_en_d[irq_idx] && chk_addr_d[irq_idx] == chk_ins_d));

  // R6: no lower-numbered enabled entry also matched
  assert_lowest_R6: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !chk_lower);
endmodule

// File: tb/addr_match_irq_tb.sv
module addr_match_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_word = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ins_start = 1'b0;
  logic [23:0] ins_addr = '0;
  logic        irq_req;
  logic [2:0]  irq_idx;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_match_irq u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_word(cfg_word),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ins_start(ins_start), .ins_addr(ins_addr), .irq_req(irq_req), .irq_idx(irq_idx)
  );

  function automatic logic [5:0] word_of(input int e);
    logic [5:0] tbl [8] = '{6'd4, 6'd5, 6'd6, 6'd7, 6'd10, 6'd11, 6'd14, 6'd15};
    return tbl[e];
  endfunction

  function automatic logic [23:0] val_of(input int e);
    return 24'h100000 * e + 24'h000340 + e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = w; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [5:0] w, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic do_start(input logic [23:0] a, output logic req, output logic [2:0] idx);
    @(negedge clk);
    ins_start = 1'b1; ins_addr = a;
    @(negedge clk);
    ins_start = 1'b0;
    req = irq_req; idx = irq_idx;
  endtask

  task automatic set_enables(input logic [7:0] en);
    cfg_write(6'd2, 4'b0010, {16'h0, en, 8'h0});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic r; logic [2:0] ix;
    chk("R2 irq_req after reset", {31'h0, irq_req}, 32'h0);
    chk("R2 irq_idx after reset", {29'h0, irq_idx}, 32'h0);
    cfg_read(6'd2, d);  chk("R2 enable word", d, 32'h0);
    cfg_read(word_of(3), d); chk("R2 entry3 addr", d, 32'h0);
    do_start(24'h000000, r, ix);
    chk("R3 disabled entry at 0 no request", {31'h0, r}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    for (int e = 0; e < 8; e++) cfg_write(word_of(e), 4'b0111, {8'h0, val_of(e)});
    for (int e = 0; e < 8; e++) begin
      cfg_read(word_of(e), d);
      chk($sformatf("R1 entry%0d readback", e), d, {8'h0, val_of(e)});
    end
    cfg_write(word_of(3), 4'b0010, 32'hEEEEAB55);
    cfg_read(word_of(3), d);
    chk("R1 middle byte only", d, {8'h0, val_of(3)[23:16], 8'hAB, val_of(3)[7:0]});
    cfg_write(word_of(3), 4'b1111, {8'hFF, val_of(3)});
    cfg_read(word_of(3), d);
    chk("R8 lane3 write ignored reads zero", d, {8'h0, val_of(3)});
    cfg_read(6'd3, d);
    chk("R8 unmapped word reads zero", d, 32'h0);
    set_enables(8'hFF);
    cfg_read(6'd2, d);
    chk("R3 enable word readback", d, 32'h0000FF00);
  endtask

  task automatic t_match;
    logic r; logic [2:0] ix;
    do_start(val_of(5), r, ix);
    chk("R4 request on entry5", {31'h0, r}, 32'h1);
    chk("R4 index entry5", {29'h0, ix}, 32'd5);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'h0, irq_req}, 32'h0);
    cfg_write(word_of(7), 4'b0111, 32'h00FFFFFF);
    do_start(24'hFFFFFF, r, ix);
    chk("R4 top of range entry7", {28'h0, r, ix}, {28'h0, 1'b1, 3'd7});
    do_start(24'h7A7A7A, r, ix);
    chk("R4 no match no request", {31'h0, r}, 32'h0);
  endtask

  task automatic t_no_start;
    bit seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ins_start = 1'b0; ins_addr = val_of(k);
      @(negedge clk);
      if (irq_req) seen = 1'b1;
    end
    chk("R5 data addresses without start", {31'h0, seen}, 32'h0);
  endtask

  task automatic t_disable;
    logic r; logic [2:0] ix;
    set_enables(8'hDF);
    do_start(val_of(5), r, ix);
    chk("R3 disabled entry5 no request", {31'h0, r}, 32'h0);
    do_start(val_of(4), r, ix);
    chk("R3 enabled entry4 still fires", {28'h0, r, ix}, {28'h0, 1'b1, 3'd4});
  endtask

  task automatic t_prio;
    logic r; logic [2:0] ix;
    cfg_write(word_of(2), 4'b0111, 32'h00ABCDEF);
    cfg_write(word_of(6), 4'b0111, 32'h00ABCDEF);
    do_start(24'hABCDEF, r, ix);
    chk("R6 lowest of 2 and 6", {28'h0, r, ix}, {28'h0, 1'b1, 3'd2});
    set_enables(8'hDB);
    do_start(24'hABCDEF, r, ix);
    chk("R6 entry6 when 2 disabled", {28'h0, r, ix}, {28'h0, 1'b1, 3'd6});
  endtask

  task automatic t_same_cycle;
    logic r; logic [2:0] ix;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = word_of(1); cfg_be = 4'b0111; cfg_wdata = 32'h00C0FFEE;
    ins_start = 1'b1; ins_addr = val_of(1);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; ins_start = 1'b0;
    chk("R7 old address used in write cycle", {28'h0, irq_req, irq_idx}, {28'h0, 1'b1, 3'd1});
    do_start(24'hC0FFEE, r, ix);
    chk("R7 new address after write", {28'h0, r, ix}, {28'h0, 1'b1, 3'd1});
    do_start(val_of(1), r, ix);
    chk("R7 old address no longer matches", {31'h0, r}, 32'h0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    ins_start = 1'b1; ins_addr = val_of(0);
    @(negedge clk);
    ins_addr = val_of(3);
    chk("R9 first of pair", {28'h0, irq_req, irq_idx}, {28'h0, 1'b1, 3'd0});
    @(negedge clk);
    ins_start = 1'b0;
    chk("R9 second of pair", {28'h0, irq_req, irq_idx}, {28'h0, 1'b1, 3'd3});
    @(negedge clk);
    chk("R9 quiet after pair", {31'h0, irq_req}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_match();
    t_no_start();
    t_disable();
    t_prio();
    t_same_cycle();
    t_back_to_back();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule